// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit tri-state buses, A and B. Each bus can be left undriven, can carry the current value of the other bus, or can carry a value stored earlier. Two independent snapshot registers hold bus data. One snapshot register takes the A bus and the other takes the B bus. Each register loads on the rising edge of its own strobe input. The strobes are sampled against the block clock, so a strobe does not have to be a clock itself.

A snapshot is taken on every strobe rise, whatever the drive and select inputs are doing. This means a bus can be recorded even while the block is driving that bus. There is one enable per bus: an active-high enable for B and an active-low enable for A. Each bus also has its own select, which chooses the live value from the opposite bus or the opposite register.

The block has a loopback mode. It is entered when both buses are driven and both selects ask for live data. In loopback, each bus reinforces the other, so the last value stays on the wires after every outside source has let go. This is built with a per-bus keeper register, not with the snapshot registers. Each keeper follows its bus on every clock edge outside loopback and freezes inside it.

Top module: `reg_bus_xcvr`

## Requirements
- R1: Data passes without inversion on all 8 bits. With `a_drive_n` low, `a_from_reg` low and not in loopback, `a_bus` equals the externally driven `b_bus` in the same cycle. With `b_drive_en` high, `b_from_reg` low and not in loopback, `b_bus` equals the externally driven `a_bus` in the same cycle.
- R2: With `b_drive_en` low and `a_drive_n` high, the block drives neither bus, so each bus reads back exactly the value an outside source places on it.
- R3: At a clock edge where `a_snap` is 1 and was 0 at the previous edge, the A snapshot register loads the value on `a_bus`. This happens for any setting of the enables and selects.
- R4: A snapshot register keeps its value at every edge that is not a 0-to-1 strobe transition, including edges where the strobe is held high and edges where it falls.
- R5: At a clock edge where `b_snap` is 1 and was 0 at the previous edge, the B snapshot register loads the value on `b_bus`. This happens for any setting of the enables and selects.
- R6: With `b_drive_en` high and `b_from_reg` at 1, `b_bus` shows the A snapshot register. With `a_drive_n` low and `a_from_reg` at 1, `a_bus` shows the B snapshot register. A new snapshot appears right after the edge that loads it.
- R7: With both buses driven and both selects at 1, `a_bus` shows the B register and `b_bus` shows the A register at the same time.
- R8: Loopback is active when both buses are driven and both selects are 0. In loopback, `a_bus` carries the value `b_bus` had and `b_bus` carries the value `a_bus` had, both sampled at the last clock edge before entry. Both values stay unchanged after outside sources release the buses.
- R9: `rst_n` low clears both snapshot registers and both keepers at once. The block resumes work at the third clock edge after `rst_n` returns high.
- R10: A snapshot of a bus that the block itself is driving stores the value the block drives onto it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| b_drive_en | input | 1 | 1: the block drives `b_bus` |
| a_drive_n | input | 1 | 0: the block drives `a_bus` |
| a_snap | input | 1 | Strobe; a rise stores `a_bus` into the A register |
| b_snap | input | 1 | Strobe; a rise stores `b_bus` into the B register |
| b_from_reg | input | 1 | 0: `b_bus` takes live A data; 1: it takes the A register |
| a_from_reg | input | 1 | 0: `a_bus` takes live B data; 1: it takes the B register |
| a_bus | inout | 8 | Bus A |
| b_bus | inout | 8 | Bus B |

## Verification
Live pass-through and isolation are combinational, so their results are due in the same cycle as the stimulus. A snapshot or a keeper update becomes visible just after the clock edge that samples it. After reset is released, work resumes at the third edge. The bench changes its inputs on the falling edge and compares both buses 1 ns later. Its reference model advances its registers only at the rising edge that follows, so each check falls in the cycle where the result is due.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // What a bus driver puts on its bus.
  typedef enum logic [1:0] {
    SRC_OFF    = 2'd0,
    SRC_LIVE   = 2'd1,
    SRC_STORED = 2'd2,
    SRC_HOLD   = 2'd3
  } bus_src_e;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic         strobe_q;
  logic         load;
  logic [W-1:0] q_d;

  always_comb begin
    load = strobe & ~strobe_q;
    q_d  = load ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      q        <= q_d;
    end
  end

  // R3 R5
  property p_load;
    @(posedge clk) disable iff (!rst_n) (strobe && !strobe_q) |=> (q == $past(d));
  endproperty
  snap_load_chk: assert property (p_load);

  // R4
  property p_keep;
    @(posedge clk) disable iff (!rst_n) !(strobe && !strobe_q) |=> $stable(q);
  endproperty
  snap_keep_chk: assert property (p_keep);

endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic         upd_en;
  logic [W-1:0] q_d;

  always_comb begin
    upd_en = ~freeze;
    q_d    = upd_en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  // R8
  property p_track;
    @(posedge clk) disable iff (!rst_n) !freeze |=> (q == $past(d));
  endproperty
  keep_track_chk: assert property (p_track);

  // R8
  property p_freeze;
    @(posedge clk) disable iff (!rst_n) freeze |=> $stable(q);
  endproperty
  keep_freeze_chk: assert property (p_freeze);

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
  import xcvr_pkg::*;
(
  input  logic     a_drive_n,
  input  logic     b_drive_en,
  input  logic     a_from_reg,
  input  logic     b_from_reg,
  output bus_src_e src_a,
  output bus_src_e src_b,
  output logic     loop
);

  logic a_on;
  logic b_on;

  always_comb begin
    a_on = ~a_drive_n;
    b_on = b_drive_en;
    loop = a_on & b_on & ~a_from_reg & ~b_from_reg;

    if (!a_on)           src_a = SRC_OFF;
    else if (loop)       src_a = SRC_HOLD;
    else if (a_from_reg) src_a = SRC_STORED;
    else                 src_a = SRC_LIVE;

    if (!b_on)           src_b = SRC_OFF;
    else if (loop)       src_b = SRC_HOLD;
    else if (b_from_reg) src_b = SRC_STORED;
    else                 src_b = SRC_LIVE;
  end

  // R2
  iso_chk: assert final (!(a_drive_n && !b_drive_en) ||
                         (src_a == SRC_OFF && src_b == SRC_OFF));

endmodule

// File: rtl/xcvr_bus_drv.sv
module xcvr_bus_drv
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  bus_src_e     src,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  input  logic [W-1:0] held,
  output logic         en,
  output logic [W-1:0] val
);

  always_comb begin
    en  = (src != SRC_OFF);
    val = '0;
    case (src)
      SRC_LIVE:   val = live;
      SRC_STORED: val = stored;
      SRC_HOLD:   val = held;
      default:    val = '0;
    endcase
  end

endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         b_drive_en,
  input  logic         a_drive_n,
  input  logic         a_snap,
  input  logic         b_snap,
  input  logic         b_from_reg,
  input  logic         a_from_reg,
  inout  wire  [W-1:0] a_bus,
  inout  wire  [W-1:0] b_bus
);

  logic         srst_n;
  logic [W-1:0] reg_a_q;
  logic [W-1:0] reg_b_q;
  logic [W-1:0] keep_a_q;
  logic [W-1:0] keep_b_q;
  bus_src_e     src_a;
  bus_src_e     src_b;
  logic         loop;
  logic         a_en;
  logic         b_en;
  logic [W-1:0] a_val;
  logic [W-1:0] b_val;

  xcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  xcvr_capture #(.W(W)) u_cap_a (
    .clk    (clk),
    .rst_n  (srst_n),
    .strobe (a_snap),
    .d      (a_bus),
    .q      (reg_a_q)
  );

  xcvr_capture #(.W(W)) u_cap_b (
    .clk    (clk),
    .rst_n  (srst_n),
    .strobe (b_snap),
    .d      (b_bus),
    .q      (reg_b_q)
  );

  xcvr_keeper #(.W(W)) u_keep_a (
    .clk    (clk),
    .rst_n  (srst_n),
    .freeze (loop),
    .d      (a_bus),
    .q      (keep_a_q)
  );

  xcvr_keeper #(.W(W)) u_keep_b (
    .clk    (clk),
    .rst_n  (srst_n),
    .freeze (loop),
    .d      (b_bus),
    .q      (keep_b_q)
  );

  xcvr_route u_route (
    .a_drive_n  (a_drive_n),
    .b_drive_en (b_drive_en),
    .a_from_reg (a_from_reg),
    .b_from_reg (b_from_reg),
    .src_a      (src_a),
    .src_b      (src_b),
    .loop       (loop)
  );

  xcvr_bus_drv #(.W(W)) u_drv_a (
    .src    (src_a),
    .live   (b_bus),
    .stored (reg_b_q),
    .held   (keep_b_q),
    .en     (a_en),
    .val    (a_val)
  );

  xcvr_bus_drv #(.W(W)) u_drv_b (
    .src    (src_b),
    .live   (a_bus),
    .stored (reg_a_q),
    .held   (keep_a_q),
    .en     (b_en),
    .val    (b_val)
  );

  assign a_bus = a_en ? a_val : {W{1'bz}};
  assign b_bus = b_en ? b_val : {W{1'bz}};

  // R7
  property p_swap;
    @(posedge clk) disable iff (!srst_n)
      (!a_drive_n && b_drive_en && a_from_reg && b_from_reg) |->
        (a_bus == reg_b_q && b_bus == reg_a_q);
  endproperty
  swap_out_chk: assert property (p_swap);

endmodule

// File: tb/reg_bus_xcvr_test.sv
module reg_bus_xcvr_test;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic b_drive_en, a_drive_n, a_snap, b_snap, b_from_reg, a_from_reg;
  logic         ext_a_en, ext_b_en;
  logic [W-1:0] ext_a, ext_b;
  wire  [W-1:0] a_bus;
  wire  [W-1:0] b_bus;

  assign a_bus = ext_a_en ? ext_a : {W{1'bz}};
  assign b_bus = ext_b_en ? ext_b : {W{1'bz}};

  reg_bus_xcvr #(.W(W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .b_drive_en (b_drive_en),
    .a_drive_n  (a_drive_n),
    .a_snap     (a_snap),
    .b_snap     (b_snap),
    .b_from_reg (b_from_reg),
    .a_from_reg (a_from_reg),
    .a_bus      (a_bus),
    .b_bus      (b_bus)
  );

  always #4 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // behavioural reference state
  logic [W-1:0] m_ra, m_rb, m_ka, m_kb;
  bit m_ra_ok, m_rb_ok, m_ka_ok, m_kb_ok;
  bit m_pa, m_pb;
  int m_rel_edges;

  task automatic compare(string tag, string bus, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s bus %s actual=%02h expected=%02h at %0t", tag, bus, act, exp, $time);
    end
  endtask

  task automatic zero_model();
    m_ra = '0; m_rb = '0; m_ka = '0; m_kb = '0;
    m_ra_ok = 1; m_rb_ok = 1; m_ka_ok = 1; m_kb_ok = 1;
    m_pa = 0; m_pb = 0;
  endtask

  // Inputs were set at the falling edge; check, then advance the model to the next rising edge.
  task automatic step(string tag);
    bit loop_m, a_on, b_on, ea_ok, eb_ok, a_live, b_live;
    logic [W-1:0] ea, eb;
    #1;
    if (!rst_n) begin zero_model(); m_rel_edges = 0; end
    a_on = !a_drive_n;
    b_on = b_drive_en;
    loop_m = a_on && b_on && !a_from_reg && !b_from_reg;
    a_live = 0; b_live = 0;
    ea = '0; eb = '0; ea_ok = 0; eb_ok = 0;
    if (a_on) begin
      if (loop_m)          begin ea = m_kb; ea_ok = m_kb_ok; end
      else if (a_from_reg) begin ea = m_rb; ea_ok = m_rb_ok; end
      else a_live = 1;
    end else if (ext_a_en) begin ea = ext_a; ea_ok = 1; end
    if (b_on) begin
      if (loop_m)          begin eb = m_ka; eb_ok = m_ka_ok; end
      else if (b_from_reg) begin eb = m_ra; eb_ok = m_ra_ok; end
      else b_live = 1;
    end else if (ext_b_en) begin eb = ext_b; eb_ok = 1; end
    if (a_live) begin ea = eb; ea_ok = eb_ok; end
    if (b_live) begin eb = ea; eb_ok = ea_ok; end
    if (ea_ok) compare(tag, "A", a_bus, ea);
    if (eb_ok) compare(tag, "B", b_bus, eb);
    // next state at the coming rising edge
    if (!rst_n || m_rel_edges < 2) begin
      zero_model();
      if (rst_n) m_rel_edges++;
    end else begin
      if (a_snap && !m_pa) begin m_ra = ea; m_ra_ok = ea_ok; end
      if (b_snap && !m_pb) begin m_rb = eb; m_rb_ok = eb_ok; end
      if (!loop_m) begin
        m_ka = ea; m_ka_ok = ea_ok;
        m_kb = eb; m_kb_ok = eb_ok;
      end
      m_pa = a_snap; m_pb = b_snap;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctl(bit ben, bit an, bit bsel, bit asel);
    b_drive_en = ben; a_drive_n = an; b_from_reg = bsel; a_from_reg = asel;
  endtask

  task automatic ext(bit ae, logic [W-1:0] av, bit be, logic [W-1:0] bv);
    ext_a_en = ae; ext_a = av; ext_b_en = be; ext_b = bv;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 0; a_snap = 0; b_snap = 0;
    ctl(0, 1, 0, 0);
    ext(1, 8'h00, 1, 8'h00);
    zero_model(); m_rel_edges = 0;
    @(negedge clk);
    step("R9"); step("R9");
    rst_n = 1;
    repeat (3) step("R9");
    // R9: both registers read back zero
    ext(0, '0, 0, '0); ctl(1, 0, 1, 1);
    step("R9");

    // R2: isolation, values that would collide with any drive
    ctl(0, 1, 0, 0); ext(1, 8'h5A, 1, 8'hC3); step("R2");
    ext(1, 8'h00, 1, 8'hFF); step("R2");

    // R1: A to B live, then B to A live
    ctl(1, 1, 0, 0);
    foreach (ext_a[i]) begin
      ext(1, 8'h01 << i, 0, '0); step("R1");
    end
    ext(1, 8'hA5, 0, '0); step("R1");
    ctl(0, 0, 0, 0);
    ext(0, '0, 1, 8'h3C); step("R1");
    ext(0, '0, 1, 8'hFE); step("R1");

    // R3: capture A in isolation mode, read on B
    ctl(0, 1, 0, 0); ext(1, 8'h69, 1, 8'h11);
    a_snap = 1; step("R3");
    a_snap = 0; ext(1, 8'h00, 0, '0); ctl(1, 1, 1, 0); step("R3"); step("R3");

    // R4: strobe held high and falling, A changes, register stays
    a_snap = 1; ext(1, 8'h42, 0, '0); ctl(1, 1, 1, 0); step("R4");
    ext(1, 8'h24, 0, '0); step("R4"); step("R4");
    a_snap = 0; ext(1, 8'h81, 0, '0); step("R4"); step("R4");

    // R5: capture B while A drives live from B
    ctl(0, 0, 0, 0); ext(0, '0, 1, 8'hB7);
    b_snap = 1; step("R5");
    b_snap = 0; ctl(0, 0, 0, 1); ext(0, '0, 1, 8'h00); step("R5"); step("R6");

    // R6: stored readout on each bus, new snapshot right after its edge
    ctl(1, 1, 1, 0); ext(1, 8'hD2, 0, '0);
    a_snap = 1; step("R6");
    a_snap = 0; step("R6");

    // R7: both stored
    ctl(1, 0, 1, 1); ext(0, '0, 0, '0); step("R7"); step("R7");

    // R10: snapshot of A while A carries the B register
    a_snap = 1; step("R10");
    a_snap = 0; step("R10"); step("R10");
    // R10: snapshot of B while B carries live A
    ctl(1, 1, 0, 0); ext(1, 8'h5C, 0, '0);
    b_snap = 1; step("R10");
    b_snap = 0; ctl(1, 0, 1, 1); ext(0, '0, 0, '0); step("R10");

    // R8: loopback, then outside release
    ctl(1, 1, 0, 0); ext(1, 8'h96, 0, '0); step("R8"); step("R8");
    ctl(1, 0, 0, 0); step("R8");
    ext(0, '0, 0, '0);
    repeat (4) step("R8");
    // R8: entry from isolation with different bus values swaps them
    ctl(0, 1, 0, 0); ext(1, 8'h0F, 1, 8'hF0); step("R8");
    ctl(1, 0, 0, 0); ext(0, '0, 0, '0); step("R8"); step("R8");

    // R9: asynchronous reset clears registers and keepers
    rst_n = 0; ctl(1, 0, 1, 1); step("R9");
    rst_n = 1; repeat (3) step("R9");

    // mixed sweep
    for (int n = 0; n < 300; n++) begin
      string tg;
      ctl($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
      a_snap = $urandom % 2; b_snap = $urandom % 2;
      ext(a_drive_n, $urandom, !b_drive_en, $urandom);
      if (!a_drive_n && b_drive_en && !a_from_reg && !b_from_reg) tg = "R8";
      else if (!a_drive_n && b_drive_en) tg = "R7";
      else if (a_from_reg || b_from_reg) tg = "R6";
      else tg = "R1";
      step(tg);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule